// File: doc/BRIEF.md
# Cartridge PRG Bank Mapper

This block is the CPU-side address controller of an 8-bit game cartridge. Each cycle it takes a 16-bit CPU address, a data byte and separate read and write strobes. From these it decides whether the access goes to program ROM, to work RAM, or to nothing at all. For a ROM access it gives a 4 KiB page number and the full ROM byte address. For a RAM access it gives the work-RAM byte address. The ROM and RAM arrays sit outside the block, and the block drives their selects.

The memory layout is interleaved. Work RAM appears both below the ROM space and in a 4 KiB hole inside it. Two 8 KiB ROM windows can be switched. The other ROM windows are fixed, and three of those fixed pages are counted back from the end of the ROM. Software loads the bank registers through an index/data port pair. Every page number wraps modulo the ROM page count, and that count is a parameter.

Top module: `prg_bank_mapper`

## Requirements
- R1: A write whose address ANDed with 0xE001 equals 0x8000 loads the low 3 data bits into the index register on the next clock edge.
- R2: A write whose address ANDed with 0xE001 equals 0x8001 loads the full data byte into the register the index selects. Register 6 selects the low switchable window and register 7 selects the high switchable window.
- R3: Writes in 0xA000–0xBFFF change no register and do not change the index. Writes whose masked address matches neither port value also change nothing, which includes 0xC000 and 0xC001.
- R4: 0x6000–0x6FFF selects work RAM at address {0, addr[11:0]} and 0xB000–0xBFFF selects it at {1, addr[11:0]}. `ram_cs` is high on a read or a write in either window, and `ram_we` is high on a write.
- R5: Reads in 0x7000–0x7FFF use ROM page 15 mod ROM_PAGES.
- R6: Reads at 0x8xxx use page reg6×2 and reads at 0x9xxx use page reg6×2+1. Reads at 0xCxxx use page reg7×2 and reads at 0xDxxx use page reg7×2+1.
- R7: Reads at 0xAxxx use page ROM_PAGES−4, reads at 0xExxx use ROM_PAGES−2, and reads at 0xFxxx use ROM_PAGES−1. Each of these is taken modulo ROM_PAGES.
- R8: Every page number wraps modulo ROM_PAGES, and `rom_addr` equals page×4096 + addr[11:0].
- R9: Reset clears the index and all registers, so that 0x8xxx reads page 0 and 0x9xxx reads page 1.
- R10: Addresses below 0x6000 assert neither select. A read there raises `open_bus`.
- R11: A register write affects only accesses that start after the clock edge that stores it. During the write cycle itself, the outputs still follow the old value.
- R12: `rom_cs` is asserted only on reads. A write into ROM space selects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| rom_cs | output | 1 | ROM select (reads only) |
| rom_page | output | PAGE_W (5) | Wrapped 4 KiB ROM page |
| rom_addr | output | PAGE_W+12 (17) | ROM byte address |
| ram_cs | output | 1 | Work-RAM select |
| ram_we | output | 1 | Work-RAM write enable |
| ram_addr | output | 13 | Work-RAM byte address |
| open_bus | output | 1 | Read below 0x6000, not driven by the cartridge |

## Verification
Selects and addresses are combinational, so they are due in the same cycle as the address that causes them. The bench samples them one time unit after it drives the inputs on the falling edge. Register and index loads appear only after the next rising edge. The reference model therefore applies a write to its own state only after that edge, and each write cycle is checked against the old register values. One step writes register 6 through the port at 0x8001 and then reads 0x8xxx. This step confirms that the new bank shows up exactly one cycle later and not earlier.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_RAM  = 2'd1,
      TGT_ROM  = 2'd2
   } tgt_e;

   // Page index counted back from the end of ROM, reduced into range.
   function automatic int back_page(input int pages, input int back);
      int v;
      v = (pages - back) % pages;
      if (v < 0) v = v + pages;
      return v;
   endfunction

   function automatic int fwd_page(input int pages, input int page);
      return page % pages;
   endfunction

endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile #(
   parameter int DATA_W    = 8,
   parameter int REG_COUNT = 8,
   parameter int LO_IDX    = 6,
   parameter int HI_IDX    = 7,
   localparam int IDX_W    = $clog2(REG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [2:0]        addr_top,   // cpu_addr[15:13]
   input  logic              addr_lsb,   // cpu_addr[0]
   input  logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  idx_q,
   output logic [DATA_W-1:0] sel_lo,
   output logic [DATA_W-1:0] sel_hi
);

   localparam logic [IDX_W-1:0] LO_SEL = IDX_W'(LO_IDX);
   localparam logic [IDX_W-1:0] HI_SEL = IDX_W'(HI_IDX);

   logic port_space;
   logic idx_hit;
   logic data_hit;

   // Ports live in 0x8000-0x9FFF and 0xC000-0xFFFF; the 0xE001 mask
   // further narrows the match to bits 15:13 == 3'b100.
   assign port_space = addr_top[2] && (addr_top[1:0] != 2'b01);
   assign idx_hit    = cpu_wr && port_space && (addr_top == 3'b100) && !addr_lsb;
   assign data_hit   = cpu_wr && port_space && (addr_top == 3'b100) &&  addr_lsb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         sel_lo <= '0;
         sel_hi <= '0;
      end else if (idx_hit) begin
         idx_q <= wdata[IDX_W-1:0];
      end else if (data_hit) begin
         if (idx_q == LO_SEL) sel_lo <= wdata;
         if (idx_q == HI_SEL) sel_hi <= wdata;
      end
   end

endmodule

// File: rtl/mapper_window_decode.sv
module mapper_window_decode
   import mapper_pkg::*;
#(
   parameter int ROM_PAGES = 32,
   parameter int DATA_W    = 8,
   parameter int RAW_W     = 9
) (
   input  logic [3:0]        nib,
   input  logic [DATA_W-1:0] sel_lo,
   input  logic [DATA_W-1:0] sel_hi,
   output tgt_e              tgt,
   output logic              ram_page,
   output logic [RAW_W-1:0]  raw_page
);

   localparam int P_FIX15 = fwd_page(ROM_PAGES, 15);
   localparam int P_BACK4 = back_page(ROM_PAGES, 4);
   localparam int P_BACK2 = back_page(ROM_PAGES, 2);
   localparam int P_BACK1 = back_page(ROM_PAGES, 1);

   logic [RAW_W-1:0] lo_even;
   logic [RAW_W-1:0] hi_even;

   assign lo_even = RAW_W'({sel_lo, 1'b0});
   assign hi_even = RAW_W'({sel_hi, 1'b0});

   always_comb begin
      tgt      = TGT_NONE;
      ram_page = 1'b0;
      raw_page = '0;
      unique case (nib)
         4'h6: begin tgt = TGT_RAM; ram_page = 1'b0; end
         4'hB: begin tgt = TGT_RAM; ram_page = 1'b1; end
         4'h7: begin tgt = TGT_ROM; raw_page = RAW_W'(P_FIX15); end
         4'h8: begin tgt = TGT_ROM; raw_page = lo_even; end
         4'h9: begin tgt = TGT_ROM; raw_page = lo_even | RAW_W'(1); end
         4'hA: begin tgt = TGT_ROM; raw_page = RAW_W'(P_BACK4); end
         4'hC: begin tgt = TGT_ROM; raw_page = hi_even; end
         4'hD: begin tgt = TGT_ROM; raw_page = hi_even | RAW_W'(1); end
         4'hE: begin tgt = TGT_ROM; raw_page = RAW_W'(P_BACK2); end
         4'hF: begin tgt = TGT_ROM; raw_page = RAW_W'(P_BACK1); end
         default: begin tgt = TGT_NONE; end
      endcase
   end

endmodule

// File: rtl/mapper_page_wrap.sv
module mapper_page_wrap #(
   parameter int ROM_PAGES = 32,
   parameter int RAW_W     = 9,
   parameter int PAGE_W    = 5
) (
   input  logic [RAW_W-1:0]  raw_page,
   output logic [PAGE_W-1:0] page
);

   localparam bit IS_POW2 = (ROM_PAGES & (ROM_PAGES - 1)) == 0;

   generate
      if (IS_POW2) begin : g_mask
         assign page = PAGE_W'(raw_page & RAW_W'(ROM_PAGES - 1));
      end else begin : g_modulo
         assign page = PAGE_W'(raw_page % RAW_W'(ROM_PAGES));
      end
   endgenerate

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
   import mapper_pkg::*;
#(
   parameter int ROM_PAGES = 32,
   parameter int PAGE_BITS = 12,
   parameter int DATA_W    = 8,
   parameter int REG_COUNT = 8,
   parameter int LO_IDX    = 6,
   parameter int HI_IDX    = 7,
   localparam int PAGE_W   = (ROM_PAGES > 1) ? $clog2(ROM_PAGES) : 1,
   localparam int ROM_AW   = PAGE_W + PAGE_BITS,
   localparam int RAM_AW   = PAGE_BITS + 1,
   localparam int IDX_W    = $clog2(REG_COUNT),
   localparam int RAW_W    = (DATA_W + 1 > PAGE_W) ? DATA_W + 1 : PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   output logic              rom_cs,
   output logic [PAGE_W-1:0] rom_page,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              ram_cs,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              open_bus
);

   generate
      if (ROM_PAGES < 1) begin : g_bad_pages
         $error("ROM_PAGES must be at least 1");
      end
      if (PAGE_BITS != 12) begin : g_bad_pagebits
         $error("window decode assumes 4 KiB pages");
      end
      if (REG_COUNT != 8) begin : g_bad_regs
         $error("index port stores three bits, REG_COUNT must be 8");
      end
      if (DATA_W < IDX_W) begin : g_bad_data
         $error("DATA_W too narrow for the index");
      end
      if (LO_IDX >= REG_COUNT || HI_IDX >= REG_COUNT || LO_IDX == HI_IDX) begin : g_bad_sel
         $error("bank select indices out of range or equal");
      end
   endgenerate

   logic [IDX_W-1:0]  cur_idx;
   logic [DATA_W-1:0] bank_lo;
   logic [DATA_W-1:0] bank_hi;
   tgt_e              tgt;
   logic              ram_page;
   logic [RAW_W-1:0]  raw_page;
   logic              any_access;

   mapper_regfile #(
      .DATA_W   (DATA_W),
      .REG_COUNT(REG_COUNT),
      .LO_IDX   (LO_IDX),
      .HI_IDX   (HI_IDX)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_wr  (cpu_wr),
      .addr_top(cpu_addr[15:13]),
      .addr_lsb(cpu_addr[0]),
      .wdata   (cpu_wdata),
      .idx_q   (cur_idx),
      .sel_lo  (bank_lo),
      .sel_hi  (bank_hi)
   );

   mapper_window_decode #(
      .ROM_PAGES(ROM_PAGES),
      .DATA_W   (DATA_W),
      .RAW_W    (RAW_W)
   ) u_decode (
      .nib     (cpu_addr[15:12]),
      .sel_lo  (bank_lo),
      .sel_hi  (bank_hi),
      .tgt     (tgt),
      .ram_page(ram_page),
      .raw_page(raw_page)
   );

   mapper_page_wrap #(
      .ROM_PAGES(ROM_PAGES),
      .RAW_W    (RAW_W),
      .PAGE_W   (PAGE_W)
   ) u_wrap (
      .raw_page(raw_page),
      .page    (rom_page)
   );

   assign any_access = cpu_rd || cpu_wr;
   assign rom_cs     = cpu_rd && (tgt == TGT_ROM);
   assign ram_cs     = any_access && (tgt == TGT_RAM);
   assign ram_we     = cpu_wr && (tgt == TGT_RAM);
   assign open_bus   = cpu_rd && (cpu_addr < 16'h6000);
   assign rom_addr   = {rom_page, cpu_addr[PAGE_BITS-1:0]};
   assign ram_addr   = {ram_page, cpu_addr[PAGE_BITS-1:0]};

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
   parameter int ROM_PAGES = 32,
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 5,
   parameter int IDX_W     = 3,
   parameter int LO_IDX    = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        addr_nib,
   input logic              addr_lsb,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic              rom_cs,
   input logic [PAGE_W-1:0] rom_page,
   input logic              ram_cs,
   input logic              ram_page,
   input logic              open_bus,
   input logic [IDX_W-1:0]  cur_idx,
   input logic [DATA_W-1:0] bank_lo,
   input logic [DATA_W-1:0] bank_hi
);

   localparam logic [PAGE_W-1:0] EXP15   = PAGE_W'(15 % ROM_PAGES);
   localparam logic [PAGE_W-1:0] EXPLAST = PAGE_W'(ROM_PAGES - 1);
   localparam logic [IDX_W-1:0]  LO_SEL  = IDX_W'(LO_IDX);

   logic idx_port;
   logic dat_port;
   logic hole;

   assign idx_port = cpu_wr && (addr_nib[3:1] == 3'b100) && !addr_lsb;
   assign dat_port = cpu_wr && (addr_nib[3:1] == 3'b100) &&  addr_lsb;
   assign hole     = addr_nib[3:1] == 3'b101;

   a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
      idx_port |=> cur_idx == $past(cpu_wdata[IDX_W-1:0]));

   a_r2_low_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
      dat_port && cur_idx == LO_SEL |=> bank_lo == $past(cpu_wdata));

   a_r3_hole_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr && hole |=> $stable(bank_lo) && $stable(bank_hi) && $stable(cur_idx));

   a_r4_ram_page_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ram_cs |-> ram_page == (addr_nib == 4'hB));

   a_r5_fixed_fifteen: assert property (@(posedge clk) disable iff (!rst_n)
      rom_cs && addr_nib == 4'h7 |-> rom_page == EXP15);

   a_r7_last_page: assert property (@(posedge clk) disable iff (!rst_n)
      rom_cs && addr_nib == 4'hF |-> rom_page == EXPLAST);

   a_r9_reset_clears: assert property (@(posedge clk)
      rst_n && $past(!rst_n) |-> cur_idx == '0 && bank_lo == '0 && bank_hi == '0);

   a_r10_open_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      open_bus |-> !rom_cs && !ram_cs);

   a_r12_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |-> !rom_cs);

endmodule

bind prg_bank_mapper mapper_checker #(
   .ROM_PAGES(ROM_PAGES),
   .DATA_W   (DATA_W),
   .PAGE_W   (PAGE_W),
   .IDX_W    (IDX_W),
   .LO_IDX   (LO_IDX)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr_nib (cpu_addr[15:12]),
   .addr_lsb (cpu_addr[0]),
   .cpu_wdata(cpu_wdata),
   .cpu_rd   (cpu_rd),
   .cpu_wr   (cpu_wr),
   .rom_cs   (rom_cs),
   .rom_page (rom_page),
   .ram_cs   (ram_cs),
   .ram_page (ram_addr[RAM_AW-1]),
   .open_bus (open_bus),
   .cur_idx  (cur_idx),
   .bank_lo  (bank_lo),
   .bank_hi  (bank_hi)
);

// File: tb/prg_bank_mapper_bench.sv
`timescale 1ns/1ps
module prg_bank_mapper_bench;

   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic        rom_cs;
   logic [4:0]  rom_page;
   logic [16:0] rom_addr;
   logic        ram_cs;
   logic        ram_we;
   logic [12:0] ram_addr;
   logic        open_bus;

   int checks = 0;
   int errors = 0;
   int m_idx;
   int m_reg [8];

   always #2.5 clk = ~clk;

   prg_bank_mapper #(.ROM_PAGES(N)) u_prg_bank_mapper (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_cs(rom_cs), .rom_page(rom_page),
      .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_we(ram_we),
      .ram_addr(ram_addr), .open_bus(open_bus)
   );

   function automatic int wrapm(input int v);
      int r;
      r = v % N;
      if (r < 0) r = r + N;
      return r;
   endfunction

   function automatic int exp_page(input int nib);
      case (nib)
         7:  return wrapm(15);
         8:  return wrapm(m_reg[6] * 2);
         9:  return wrapm(m_reg[6] * 2 + 1);
         10: return wrapm(N - 4);
         12: return wrapm(m_reg[7] * 2);
         13: return wrapm(m_reg[7] * 2 + 1);
         14: return wrapm(N - 2);
         15: return wrapm(N - 1);
         default: return 0;
      endcase
   endfunction

   task automatic fail(input string tag, input string what, input int got, input int exp);
      errors++;
      $display("FAIL %s %s addr=%h got=%0d expected=%0d", tag, what, cpu_addr, got, exp);
   endtask

   task automatic step(input logic [15:0] a, input logic [7:0] d,
                       input logic rd, input logic wr, input string tag);
      int nib;
      bit e_rom, e_ram, e_we, e_ob;
      int e_page;
      cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
      #1;
      nib    = int'(a[15:12]);
      e_rom  = rd && (nib >= 7) && (nib != 11);
      e_ram  = (rd || wr) && (nib == 6 || nib == 11);
      e_we   = wr && e_ram;
      e_ob   = rd && (a < 16'h6000);
      e_page = exp_page(nib);
      checks++;
      if (rom_cs != e_rom)        fail(tag, "rom_cs", int'(rom_cs), int'(e_rom));
      else if (ram_cs != e_ram)   fail(tag, "ram_cs", int'(ram_cs), int'(e_ram));
      else if (ram_we != e_we)    fail(tag, "ram_we", int'(ram_we), int'(e_we));
      else if (open_bus != e_ob)  fail(tag, "open_bus", int'(open_bus), int'(e_ob));
      else if (e_rom && int'(rom_page) != e_page)
         fail(tag, "rom_page", int'(rom_page), e_page);
      else if (e_rom && int'(rom_addr) != e_page * 4096 + int'(a[11:0]))
         fail(tag, "rom_addr", int'(rom_addr), e_page * 4096 + int'(a[11:0]));
      else if (e_ram && int'(ram_addr) != ((nib == 11) ? 4096 : 0) + int'(a[11:0]))
         fail(tag, "ram_addr", int'(ram_addr), ((nib == 11) ? 4096 : 0) + int'(a[11:0]));
      @(posedge clk);
      if (wr && rst_n) begin
         if ((a & 16'hE001) == 16'h8000)      m_idx = int'(d) & 7;
         else if ((a & 16'hE001) == 16'h8001) m_reg[m_idx] = int'(d);
      end
      @(negedge clk);
   endtask

   task automatic do_reset();
      cpu_rd = 1'b0; cpu_wr = 1'b0; rst_n = 1'b0;
      repeat (3) @(posedge clk);
      m_idx = 0;
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R9: reset state
      step(16'h8000, 8'h00, 1, 0, "R9");
      step(16'h9123, 8'h00, 1, 0, "R9");
      // R4: work RAM windows
      step(16'h6000, 8'h00, 1, 0, "R4");
      step(16'h6ABC, 8'h5A, 0, 1, "R4");
      step(16'hB123, 8'h33, 0, 1, "R4");
      step(16'hBFFF, 8'h00, 1, 0, "R4");
      // R5, R7: fixed pages
      step(16'h7FFF, 8'h00, 1, 0, "R5");
      step(16'hA010, 8'h00, 1, 0, "R7");
      step(16'hE800, 8'h00, 1, 0, "R7");
      step(16'hF001, 8'h00, 1, 0, "R7");
      // R1, R2, R6: low bank via index 6
      step(16'h8000, 8'h06, 0, 1, "R1");
      step(16'h8001, 8'h02, 0, 1, "R2");
      step(16'h8040, 8'h00, 1, 0, "R6");
      step(16'h9FFF, 8'h00, 1, 0, "R6");
      // R1: only low 3 bits kept (0xFF -> 7)
      step(16'h8000, 8'hFF, 0, 1, "R1");
      step(16'h9001, 8'h03, 0, 1, "R2");
      step(16'hC000, 8'h00, 1, 0, "R6");
      step(16'hD234, 8'h00, 1, 0, "R6");
      // R3: hole and unmatched writes ignored
      step(16'hA000, 8'h06, 0, 1, "R3");
      step(16'hA001, 8'h00, 0, 1, "R3");
      step(16'hC001, 8'h09, 0, 1, "R3");
      step(16'hC000, 8'h06, 0, 1, "R3");
      step(16'hC000, 8'h00, 1, 0, "R3");
      step(16'h8000, 8'h00, 1, 0, "R3");
      // R11: write to reg 6 while reading its own window shows old page
      step(16'h8000, 8'h06, 0, 1, "R11");
      step(16'h8001, 8'h0A, 1, 1, "R11");
      step(16'h8000, 8'h00, 1, 0, "R11");
      // R8: wrap modulo page count
      step(16'h8001, 8'd20, 0, 1, "R8");
      step(16'h8123, 8'h00, 1, 0, "R8");
      step(16'h9456, 8'h00, 1, 0, "R8");
      step(16'h8000, 8'h07, 0, 1, "R8");
      step(16'h8001, 8'hFF, 0, 1, "R8");
      step(16'hC789, 8'h00, 1, 0, "R8");
      step(16'hDABC, 8'h00, 1, 0, "R8");
      // R10: below 0x6000
      step(16'h0000, 8'h00, 1, 0, "R10");
      step(16'h4020, 8'h00, 1, 0, "R10");
      step(16'h5FFF, 8'h00, 1, 0, "R10");
      step(16'h2000, 8'h77, 0, 1, "R10");
      // R12: writes into ROM space select nothing
      step(16'hF000, 8'h12, 0, 1, "R12");
      step(16'h7000, 8'h12, 0, 1, "R12");
      // R9: reset mid-run clears banks
      do_reset();
      step(16'h8000, 8'h00, 1, 0, "R9");
      step(16'hD000, 8'h00, 1, 0, "R9");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule